// File: doc/BRIEF.md
# Static Memory Bus Controller

This block connects a simple 32-bit request/response port to an external asynchronous bus for flash, SRAM or memory-mapped peripherals. The bus is split into up to eight chip-select regions. Each region covers at most 16 MB, so it takes a 24-bit byte address. Each region has its own configuration word. That word sets the external data width (8 or 16 bits) and four timing counts: setup, strobe wait, hold and data float. An access of 8, 16 or 32 bits that is wider than the region's bus becomes a run of external cycles at increasing addresses. The read data from these cycles is packed little-endian into a single response. An active-low wait input from the device lengthens the strobe.

A request is taken when `req_valid` is high while `req_ready` is high. The configuration of the addressed region is captured at that moment. The state machine has five states:

- ST_IDLE waits for a request.
- ST_SETUP asserts the chip select and address for the setup count.
- ST_STROBE drives the read or byte-write strobes for wait+1 cycles and stays there while `mem_wait_n` is low at its final count.
- ST_HOLD keeps the chip select with the strobes released for the hold count.
- ST_FLOAT follows the last cycle of a read and keeps the controller off the bus for the float count.

The transitions are:

- accept: ST_IDLE to ST_SETUP, or straight to ST_STROBE when setup is 0.
- setup expiry: ST_SETUP to ST_STROBE.
- strobe end: ST_STROBE to ST_HOLD, or to beat end when hold is 0.
- hold expiry: ST_HOLD to beat end.
- beat end: back to ST_SETUP or ST_STROBE when beats remain. After the last beat it goes to ST_FLOAT (a read with a nonzero float count) or to ST_IDLE.
- float expiry: ST_FLOAT to ST_IDLE.

Top module: `sram_bus_ctrl`

## Requirements
- R1: Out of reset, all chip selects are high, the read strobe and both write strobes are high, `mem_dq_oe` is low, `req_ready` is high and `rsp_done` is low.
- R2: During an access, exactly the chip select numbered `req_cs` is low and all others are high. `mem_addr` carries the 24-bit byte address of the current external cycle.
- R3: The configuration word is laid out as bit 0 = 16-bit bus, bits 4:1 = setup, bits 9:5 = wait, bits 13:10 = hold, bits 17:14 = float. Each external cycle has `setup` cycles with the chip select low and the strobes high, then wait+1 strobe cycles, then `hold` cycles with the strobes high.
- R4: On an 8-bit region, the size codes 0 (byte), 1 (half) and 2 (word) give 1, 2 and 4 external cycles at address, address+1, and so on. The bytes go out least significant first on `mem_dq_out[7:0]`, and only `mem_we_n[0]` strobes.
- R5: On a 16-bit region, a word access takes two external cycles, at address and address+2. The low half goes out first. Byte and half accesses take one cycle.
- R6: While `mem_wait_n` is low when the strobe count has run out, the strobe stays asserted. It ends in the first cycle in which `mem_wait_n` is high.
- R7: Read data is sampled at the last strobe cycle and packed little-endian into `rsp_rdata`, with unused upper bits zero. A byte read on a 16-bit region takes the lane selected by address bit 0 (0 = bits 7:0).
- R8: After the last cycle of a read, `req_ready` and `mem_dq_oe` stay low for exactly the float count of that region, starting with the cycle that carries `rsp_done`. Writes add no float time.
- R9: Each accepted request produces exactly one `rsp_done` pulse, one cycle wide, in the cycle after the last external cycle ends.
- R10: A byte write on a 16-bit region pulls low only `mem_we_n[addr[0]]` and leaves the other byte unchanged. Half and word writes pull both low.
- R11: A configuration word written on `cfg_we` for region `cfg_sel` sets the timing of every later access accepted for that region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe for a region configuration word |
| cfg_sel | input | 3 | Region whose configuration is written |
| cfg_wdata | input | 18 | Configuration word (layout in R3) |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, so a request is taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cs | input | 3 | Target region |
| req_addr | input | 24 | Byte address inside the region |
| req_size | input | 2 | 0 byte, 1 half, 2 word |
| req_wdata | input | 32 | Write data, little-endian |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Read data, valid with `rsp_done` |
| mem_cs_n | output | 8 | Active-low chip selects |
| mem_addr | output | 24 | External byte address |
| mem_oe_n | output | 1 | Active-low read strobe |
| mem_we_n | output | 2 | Active-low write strobes, low and high byte |
| mem_dq_out | output | 16 | Data driven to the bus |
| mem_dq_oe | output | 1 | Bus driver enable for the tri-state pad |
| mem_dq_in | input | 16 | Data read from the bus |
| mem_wait_n | input | 1 | Active-low stall from the device |

## Verification
A wrong state or a wrong phase count shows up on the strobe and chip-select pins within the same external cycle. It appears as a setup, strobe or hold length that differs from the configured count, so the bench measures these lengths pin by pin for every access. A wrong beat counter or lane choice shows up as a wrong address, a wrong byte strobe or a wrong byte in the modelled memory. It also shows up in the packed read word at the next `rsp_done`. A float counter that ends early raises `req_ready` before the configured count. A missing or extra completion leaves the scoreboard queue out of step.

// File: rtl/sbc_pkg.sv
`timescale 1ns/1ps
package sbc_pkg;

    // Per-region configuration word, bit 0 is the bus width flag.
    typedef struct packed {
        logic [3:0] flt;
        logic [3:0] hold;
        logic [4:0] wt;
        logic [3:0] setup;
        logic       w16;
    } sbc_cfg_t;

    localparam int CFG_W = $bits(sbc_cfg_t);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD,
        ST_FLOAT
    } sbc_state_t;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;

    // Index of the last external cycle for a given bus width and size.
    function automatic logic [1:0] last_beat_idx(input logic w16, input logic [1:0] size);
        if (w16)
            return (size == SZ_BYTE || size == SZ_HALF) ? 2'd0 : 2'd1;
        else if (size == SZ_BYTE)
            return 2'd0;
        else if (size == SZ_HALF)
            return 2'd1;
        else
            return 2'd3;
    endfunction

endpackage

// File: rtl/sbc_cfg_bank.sv
`timescale 1ns/1ps
module sbc_cfg_bank
    import sbc_pkg::*;
#(
    parameter int NUM_CS = 8,
    localparam int CSW = $clog2(NUM_CS)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [CSW-1:0] wr_sel,
    input  sbc_cfg_t       wr_data,
    input  logic [CSW-1:0] rd_sel,
    output sbc_cfg_t       rd_cfg
);

    sbc_cfg_t regs [NUM_CS];

    for (genvar g = 0; g < NUM_CS; g++) begin : g_region
        sbc_cfg_t word_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                word_q <= '0;
            else if (wr_en && wr_sel == CSW'(g))
                word_q <= wr_data;
        end
        assign regs[g] = word_q;
    end

    assign rd_cfg = regs[rd_sel];

endmodule

// File: rtl/sbc_phase_timer.sv
`timescale 1ns/1ps
module sbc_phase_timer #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/sram_bus_ctrl.sv
`timescale 1ns/1ps
module sram_bus_ctrl
    import sbc_pkg::*;
#(
    parameter int NUM_CS = 8,
    parameter int ADDR_W = 24,
    localparam int CSW = $clog2(NUM_CS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CSW-1:0]    cfg_sel,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [CSW-1:0]    req_cs,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [31:0]       req_wdata,
    output logic              rsp_done,
    output logic [31:0]       rsp_rdata,
    output logic [NUM_CS-1:0] mem_cs_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_oe_n,
    output logic [1:0]        mem_we_n,
    output logic [15:0]       mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [15:0]       mem_dq_in,
    input  logic              mem_wait_n
);

    sbc_state_t  state, nxt;
    sbc_cfg_t    cur_cfg, cfg_q, bc;
    logic        wr_q, done_q;
    logic [CSW-1:0]    cs_q;
    logic [ADDR_W-1:0] addr_q;
    logic [1:0]  size_q, beat_q, last_q;
    logic [31:0] wdata_q, rdata_q, wsh;
    logic        t_load, t_zero, beat_end, last_beat, accept, sample, active;
    logic [4:0]  t_val, begin_ld;
    sbc_state_t  begin_st;

    sbc_cfg_bank #(.NUM_CS(NUM_CS)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_sel(cfg_sel),
        .wr_data(sbc_cfg_t'(cfg_wdata)), .rd_sel(req_cs), .rd_cfg(cur_cfg)
    );

    sbc_phase_timer #(.W(5)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .zero(t_zero)
    );

    assign accept    = (state == ST_IDLE) && req_valid;
    assign last_beat = (beat_q == last_q);
    assign sample    = (state == ST_STROBE) && t_zero && mem_wait_n && !wr_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Next state and phase counter loads
    always_comb begin
        nxt      = state;
        t_load   = 1'b0;
        t_val    = '0;
        beat_end = 1'b0;
        bc       = (state == ST_IDLE) ? cur_cfg : cfg_q;
        begin_st = (bc.setup != 4'd0) ? ST_SETUP : ST_STROBE;
        begin_ld = (bc.setup != 4'd0) ? {1'b0, bc.setup - 4'd1} : bc.wt;
        unique case (state)
            ST_IDLE: if (req_valid) begin
                nxt = begin_st; t_load = 1'b1; t_val = begin_ld;
            end
            ST_SETUP: if (t_zero) begin
                nxt = ST_STROBE; t_load = 1'b1; t_val = cfg_q.wt;
            end
            ST_STROBE: if (t_zero && mem_wait_n) begin
                if (cfg_q.hold != 4'd0) begin
                    nxt = ST_HOLD; t_load = 1'b1; t_val = {1'b0, cfg_q.hold - 4'd1};
                end else begin
                    beat_end = 1'b1;
                end
            end
            ST_HOLD:  if (t_zero) beat_end = 1'b1;
            ST_FLOAT: if (t_zero) nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
        if (beat_end) begin
            if (!last_beat) begin
                nxt = begin_st; t_load = 1'b1; t_val = begin_ld;
            end else if (!wr_q && cfg_q.flt != 4'd0) begin
                nxt = ST_FLOAT; t_load = 1'b1; t_val = {1'b0, cfg_q.flt - 4'd1};
            end else begin
                nxt = ST_IDLE;
            end
        end
    end

    // Request capture, beat tracking and read assembly
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q <= 1'b0; cs_q <= '0; addr_q <= '0; size_q <= '0;
            wdata_q <= '0; cfg_q <= '0; beat_q <= '0; last_q <= '0;
            rdata_q <= '0; done_q <= 1'b0;
        end else begin
            done_q <= beat_end && last_beat;
            if (accept) begin
                wr_q    <= req_write;
                cs_q    <= req_cs;
                addr_q  <= req_addr;
                size_q  <= req_size;
                wdata_q <= req_wdata;
                cfg_q   <= cur_cfg;
                beat_q  <= '0;
                last_q  <= last_beat_idx(cur_cfg.w16, req_size);
                rdata_q <= '0;
            end
            if (beat_end && !last_beat)
                beat_q <= beat_q + 2'd1;
            if (sample) begin
                if (!cfg_q.w16)
                    rdata_q[{beat_q, 3'b000} +: 8] <= mem_dq_in[7:0];
                else if (size_q == SZ_BYTE)
                    rdata_q[7:0] <= addr_q[0] ? mem_dq_in[15:8] : mem_dq_in[7:0];
                else
                    rdata_q[{beat_q[0], 4'b0000} +: 16] <= mem_dq_in;
            end
        end
    end

    // Bus outputs
    always_comb begin
        active     = (state == ST_SETUP) || (state == ST_STROBE) || (state == ST_HOLD);
        mem_cs_n   = active ? ~(NUM_CS'(1) << cs_q) : '1;
        mem_addr   = addr_q + ADDR_W'(cfg_q.w16 ? {beat_q, 1'b0} : {1'b0, beat_q});
        mem_oe_n   = !((state == ST_STROBE) && !wr_q);
        if (!((state == ST_STROBE) && wr_q))
            mem_we_n = 2'b11;
        else if (!cfg_q.w16)
            mem_we_n = 2'b10;
        else if (size_q == SZ_BYTE)
            mem_we_n = addr_q[0] ? 2'b01 : 2'b10;
        else
            mem_we_n = 2'b00;
        wsh        = wdata_q >> (cfg_q.w16 ? {beat_q[0], 4'b0000} : {beat_q, 3'b000});
        mem_dq_out = (cfg_q.w16 && size_q != SZ_BYTE) ? wsh[15:0] : {wsh[7:0], wsh[7:0]};
        mem_dq_oe  = active && wr_q;
        req_ready  = (state == ST_IDLE);
        rsp_done   = done_q;
        rsp_rdata  = rdata_q;
    end

    AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~mem_cs_n)); // R2
    AST_SETUP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SETUP) |-> (mem_oe_n && mem_we_n == 2'b11 && mem_cs_n != '1)); // R3
    AST_WAIT_HOLDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STROBE && !mem_wait_n) |=> (state == ST_STROBE)); // R6
    AST_FLOAT_OFF_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FLOAT) |-> (!mem_dq_oe && !req_ready && mem_cs_n == '1)); // R8
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done); // R9
    AST_BYTE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STROBE && wr_q && size_q == SZ_BYTE) |-> ($countones(~mem_we_n) == 1)); // R10

endmodule

// File: tb/sram_bus_ctrl_tb_top.sv
`timescale 1ns/1ps
module sram_bus_ctrl_tb_top;
    import sbc_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [CFG_W-1:0] cfg_wdata = '0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic        req_ready, rsp_done;
    logic [2:0]  req_cs = '0;
    logic [23:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic [31:0] req_wdata = '0, rsp_rdata;
    logic [7:0]  mem_cs_n;
    logic [23:0] mem_addr;
    logic        mem_oe_n, mem_dq_oe;
    logic [1:0]  mem_we_n;
    logic [15:0] mem_dq_out, mem_dq_in;
    logic        mem_wait_n = 1'b1;

    sram_bus_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write), .req_cs(req_cs),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .mem_cs_n(mem_cs_n), .mem_addr(mem_addr),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .mem_dq_in(mem_dq_in), .mem_wait_n(mem_wait_n)
    );

    always #2 clk = ~clk;

    int n_chk = 0, n_fail = 0, n_req = 0, n_done = 0, cyc = 0;
    logic [7:0] mdl [0:255];
    logic       w16_of [0:7];
    logic [32:0] exp_q [$];
    string       tag_q [$];
    int setup_n, strb_n, hold_n, flt_n, stb_run = 0;
    logic [7:0] cs_seen;
    logic [1:0] we_mask;
    logic flt_act = 1'b0, flt_drv = 1'b0, stretch_en = 1'b0;
    wire  strobe = !mem_oe_n || (mem_we_n != 2'b11);

    function automatic void check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endfunction

    // External device model: byte memory indexed by the low address bits
    always_comb begin
        int ci;
        ci = 0;
        for (int i = 0; i < 8; i++) if (!mem_cs_n[i]) ci = i;
        if (w16_of[ci])
            mem_dq_in = {mdl[{mem_addr[7:1], 1'b1}], mdl[{mem_addr[7:1], 1'b0}]};
        else
            mem_dq_in = {8'h00, mdl[mem_addr[7:0]]};
    end

    // Write capture, phase profile, wait stretcher
    always @(negedge clk) begin
        if (mem_cs_n != 8'hFF) begin
            int ci;
            ci = 0;
            for (int i = 0; i < 8; i++) if (!mem_cs_n[i]) ci = i;
            cs_seen = cs_seen | ~mem_cs_n;
            if (strobe) begin
                strb_n++;
                we_mask = we_mask | ~mem_we_n;
                if (w16_of[ci]) begin
                    if (!mem_we_n[0]) mdl[{mem_addr[7:1], 1'b0}] = mem_dq_out[7:0];
                    if (!mem_we_n[1]) mdl[{mem_addr[7:1], 1'b1}] = mem_dq_out[15:8];
                end else if (!mem_we_n[0]) begin
                    mdl[mem_addr[7:0]] = mem_dq_out[7:0];
                end
            end else if (strb_n == 0) setup_n++;
            else hold_n++;
        end
        if (strobe) stb_run++;
        else        stb_run = 0;
        mem_wait_n = !(stretch_en && strobe && stb_run < 5);
    end

    // Scoreboard monitor and float measurement
    always @(negedge clk) begin
        if (flt_act) begin
            if (!req_ready) begin
                flt_n++;
                if (mem_dq_oe) flt_drv = 1'b1;
            end else flt_act = 1'b0;
        end
        if (rsp_done) begin
            logic [32:0] e;
            string t;
            n_done++;
            flt_act = 1'b1; flt_drv = 1'b0;
            flt_n = req_ready ? 0 : 1;
            if (exp_q.size() == 0) begin
                n_chk++; n_fail++;
                $display("FAIL R9 unexpected done: actual=1 expected=0");
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (e[32]) check(t, rsp_rdata, e[31:0]);
                else       check("R9", 32'd1, 32'd1);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_chk++; n_fail++;
            $display("FAIL R9 watchdog: actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic set_cfg(int cs, bit w16, int s, int w, int h, int f);
        sbc_cfg_t c;
        c.w16 = w16; c.setup = 4'(s); c.wt = 5'(w); c.hold = 4'(h); c.flt = 4'(f);
        cfg_we = 1'b1; cfg_sel = 3'(cs); cfg_wdata = c;
        w16_of[cs] = w16;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic access(bit wr, int cs, logic [23:0] a, logic [1:0] sz,
                          logic [31:0] d, logic [31:0] exp, string tag);
        setup_n = 0; strb_n = 0; hold_n = 0; cs_seen = '0; we_mask = '0;
        exp_q.push_back({~wr, exp});
        tag_q.push_back(tag);
        n_req++;
        req_valid = 1'b1; req_write = wr; req_cs = 3'(cs);
        req_addr = a; req_size = sz; req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        while (exp_q.size() != 0) @(negedge clk);
        repeat (8) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mdl[i] = 8'h00;
        for (int i = 0; i < 8; i++) w16_of[i] = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 cs_n", {24'd0, mem_cs_n}, 32'hFF);
        check("R1 strobes", {29'd0, mem_oe_n, mem_we_n}, 32'h7);
        check("R1 dq_oe", {31'd0, mem_dq_oe}, 32'd0);
        check("R1 ready/done", {30'd0, req_ready, rsp_done}, 32'h2);

        set_cfg(1, 0, 1, 1, 1, 0);
        set_cfg(2, 0, 2, 3, 1, 0);
        set_cfg(3, 1, 1, 2, 0, 0);
        set_cfg(4, 0, 0, 0, 0, 6);
        set_cfg(5, 1, 0, 1, 1, 0);

        // R3 phase lengths, R2 select and address
        access(1, 2, 24'h40, 2'd0, 32'h77, 0, "R3");
        check("R3 setup", setup_n, 2);
        check("R3 strobe", strb_n, 4);
        check("R3 hold", hold_n, 1);
        check("R2 cs", {24'd0, cs_seen}, 32'h04);
        check("R2 addr", {24'd0, mdl[8'h40]}, 32'h77);
        check("R4 8-bit lane", {30'd0, we_mask}, 32'h1);
        access(0, 2, 24'h40, 2'd0, 0, 32'h77, "R7 byte read");

        // R4 word split on 8-bit region
        access(1, 1, 24'h10, 2'd2, 32'hA1B2C3D4, 0, "R4");
        check("R4 bytes", {mdl[8'h13], mdl[8'h12], mdl[8'h11], mdl[8'h10]}, 32'hA1B2C3D4);
        check("R4 strobe cycles", strb_n, 8);
        check("R2 cs", {24'd0, cs_seen}, 32'h02);
        access(0, 1, 24'h10, 2'd2, 0, 32'hA1B2C3D4, "R7 word read 8-bit");
        access(0, 1, 24'h12, 2'd1, 0, 32'h0000A1B2, "R7 half read 8-bit");

        // R5 word split on 16-bit region
        access(1, 3, 24'h20, 2'd2, 32'h11223344, 0, "R5");
        check("R5 bytes", {mdl[8'h23], mdl[8'h22], mdl[8'h21], mdl[8'h20]}, 32'h11223344);
        check("R5 strobe cycles", strb_n, 6);
        access(0, 3, 24'h20, 2'd2, 0, 32'h11223344, "R5 word read 16-bit");

        // R10 byte lanes on 16-bit region
        mdl[8'h24] = 8'hEE; mdl[8'h25] = 8'hEE;
        access(1, 3, 24'h25, 2'd0, 32'h5A, 0, "R10");
        check("R10 upper lane only", {30'd0, we_mask}, 32'h2);
        check("R10 low byte kept", {24'd0, mdl[8'h24]}, 32'hEE);
        check("R10 high byte", {24'd0, mdl[8'h25]}, 32'h5A);
        access(0, 3, 24'h25, 2'd0, 0, 32'h0000005A, "R7 odd byte read 16-bit");
        access(1, 3, 24'h24, 2'd0, 32'h3C, 0, "R10");
        check("R10 lower lane only", {30'd0, we_mask}, 32'h1);
        check("R10 high byte kept", {24'd0, mdl[8'h25]}, 32'h5A);

        // R6 wait stretch
        mdl[8'h30] = 8'h9D;
        stretch_en = 1'b1;
        access(0, 5, 24'h30, 2'd0, 0, 32'h9D, "R6 stretched read data");
        check("R6 stretched strobe", strb_n, 5);
        stretch_en = 1'b0;
        access(0, 5, 24'h30, 2'd0, 0, 32'h9D, "R6 plain read data");
        check("R6 plain strobe", strb_n, 2);

        // R8 float after reads only
        access(0, 4, 24'h40, 2'd0, 0, 32'h77, "R8 read data");
        check("R8 float cycles", flt_n, 6);
        check("R8 no drive", {31'd0, flt_drv}, 32'd0);
        access(1, 4, 24'h41, 2'd0, 32'h12, 0, "R8");
        check("R8 no float after write", flt_n, 0);

        // R11 reconfiguration
        set_cfg(2, 0, 0, 0, 2, 0);
        access(1, 2, 24'h42, 2'd0, 32'h66, 0, "R11");
        check("R11 setup", setup_n, 0);
        check("R11 strobe", strb_n, 1);
        check("R11 hold", hold_n, 2);

        // R9 completion accounting
        check("R9 done count", n_done, n_req);
        check("R9 queue empty", exp_q.size(), 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule